// File: doc/BRIEF.md
# Masked Bit Test Condition Unit

This block produces the 2-bit condition code for two operations that look at a value through a bit mask. The first operation tests the selected bits. The second reports on bytes inserted under a mask. Each request carries a value, a mask, a width select and a mode select. The code appears on a registered output one clock after the request is accepted.

The mode matters for the result. The narrow test only tells "none", "all" and "some" apart. The wide test and the insert mode also look at one value bit: the bit that sits at the most significant set position of the mask. That bit is found with a leading-zero count of the mask. The value is shifted left by that count and the top bit of the shifted value is read. The count and the decision logic are combinational and feed a single output register.

The block does not write any inserted bytes into a register. It produces only the code.

Top module: `mbt_cond_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_code` loads at that same clock edge. While `in_valid` is low, `out_code` holds its last value.
- R2: During and right after reset, `out_valid` is 0 and `out_code` is 0.
- R3: In test mode (`in_insert`=0), when the bitwise AND of value and mask is zero, the code is 0. This includes an all-zero mask.
- R4: In test mode, when the AND of value and mask equals a nonzero mask, the code is 3.
- R5: In 32-bit test mode (`in_wide`=0), a mixed result gives code 1. A mixed result means some selected bits are set and some are clear.
- R6: In 64-bit test mode (`in_wide`=1), a mixed result gives code 2 when the value bit at the mask's highest set position is 1. Otherwise it gives code 1.
- R7: In insert mode (`in_insert`=1), when the AND of value and mask is zero, the code is 0.
- R8: In insert mode with a nonzero AND, the code is 1 when the value bit at the mask's highest set position is 1. Otherwise the code is 2. Insert mode never gives 3.
- R9: With `in_wide`=0, bits 63:32 of both value and mask have no effect on the code. Within that width, "highest set position" counts only bits 31:0.
- R10: The leading-zero count of the mask is computed over the selected width. The value bit found at that count is the bit at the mask's leftmost 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_value | input | 64 | Value under test |
| in_mask | input | 64 | Bit mask |
| in_wide | input | 1 | 1 = 64-bit width, 0 = 32-bit width (low half) |
| in_insert | input | 1 | 1 = insert mode, 0 = test mode |
| out_valid | output | 1 | Code valid, one cycle after request |
| out_code | output | 2 | Condition code 0..3 |

## Verification
The input patterns are built so that each code value is reached in each mode and width:
- A value equal to the mask, a value ANDed with the mask, and the mask's complement reach "all", "mixed" and "none" respectively.
- Single-bit and top-bit-only masks, with the value bit at that position flipped, separate the leading-bit outcomes.
- Random content in the upper half during 32-bit requests shows whether the width select really hides those bits.

Idle cycles with changing inputs confirm that the code holds.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  typedef enum logic [1:0] {
    MBT_CC0 = 2'd0,
    MBT_CC1 = 2'd1,
    MBT_CC2 = 2'd2,
    MBT_CC3 = 2'd3
  } mbt_code_e;

  // Keep only the low NW bits of a W-bit word.
  function automatic logic [63:0] mbt_narrow(input logic [63:0] w, input int unsigned nw);
    logic [63:0] keep;
    keep = (nw >= 64) ? {64{1'b1}} : ((64'd1 << nw) - 64'd1);
    return w & keep;
  endfunction

  // Decision table from the three observed facts.
  function automatic mbt_code_e mbt_decide(input logic none_set, input logic all_set,
                                           input logic lead_bit, input logic wide,
                                           input logic insert);
    mbt_code_e c;
    if (none_set) c = MBT_CC0;
    else if (insert) c = lead_bit ? MBT_CC1 : MBT_CC2;
    else if (all_set) c = MBT_CC3;
    else if (!wide) c = MBT_CC1;
    else c = lead_bit ? MBT_CC2 : MBT_CC1;
    return c;
  endfunction

endpackage

// File: rtl/mbt_lzc.sv
module mbt_lzc #(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count,
  output logic          all_zero
);
  // above[i] is high when any bit at position i or higher is set.
  logic [W-1:0] above;

  genvar gi;
  generate
    for (gi = W - 1; gi >= 0; gi--) begin : g_prefix
      if (gi == W - 1) begin : g_top
        assign above[gi] = vec[gi];
      end else begin : g_rest
        assign above[gi] = vec[gi] | above[gi+1];
      end
    end
  endgenerate

  // Positions with nothing set at or above them are the leading zeros.
  assign count    = CW'(W - $countones(above));
  assign all_zero = ~above[0];

endmodule

// File: rtl/mbt_lead_pick.sv
module mbt_lead_pick #(
  parameter int W = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  input  logic [CW-1:0] shamt,
  output logic          lead_bit
);
  logic [W-1:0] shifted;

  assign shifted  = value << shamt;
  assign lead_bit = shifted[W-1];

endmodule

// File: rtl/mbt_code_eval.sv
module mbt_code_eval
  import mbt_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  input  logic         lead_bit,
  input  logic         wide,
  input  logic         insert,
  output logic         none_set,
  output logic         all_set,
  output mbt_code_e    code
);
  logic [W-1:0] sel;

  assign sel      = value & mask;
  assign none_set = (sel == '0);
  assign all_set  = (sel == mask);
  assign code     = mbt_decide(none_set, all_set, lead_bit, wide, insert);

endmodule

// File: rtl/mbt_cond_unit.sv
module mbt_cond_unit
  import mbt_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  input  logic [DATA_W-1:0] in_mask,
  input  logic              in_wide,
  input  logic              in_insert,
  output logic              out_valid,
  output logic [1:0]        out_code
);
  localparam int CW    = $clog2(DATA_W + 1);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] eff_value, eff_mask;
  logic [CW-1:0]     lz_count;
  logic              mask_zero;
  logic              lead_bit;
  logic              none_set, all_set;
  mbt_code_e         next_code;
  logic [IDX_W-1:0]  lead_idx;

  // Narrow width clears the upper half; the count over the full width then
  // still lands on the mask's leftmost 1.
  assign eff_value = in_wide ? in_value : DATA_W'(mbt_narrow(64'(in_value), NARROW_W));
  assign eff_mask  = in_wide ? in_mask  : DATA_W'(mbt_narrow(64'(in_mask), NARROW_W));

  mbt_lzc #(.W(DATA_W)) u_lzc (
    .vec      (eff_mask),
    .count    (lz_count),
    .all_zero (mask_zero)
  );

  mbt_lead_pick #(.W(DATA_W)) u_pick (
    .value    (eff_value),
    .shamt    (lz_count),
    .lead_bit (lead_bit)
  );

  mbt_code_eval #(.W(DATA_W)) u_eval (
    .value    (eff_value),
    .mask     (eff_mask),
    .lead_bit (lead_bit),
    .wide     (in_wide),
    .insert   (in_insert),
    .none_set (none_set),
    .all_set  (all_set),
    .code     (next_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= next_code;
    end
  end

  assign lead_idx = IDX_W'(DATA_W - 1) - IDX_W'(lz_count);

  // R1: output strobe follows the request by one cycle
  a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R1: code holds across idle cycles
  a_r1_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_code));
  // R3, R7: nothing selected gives code 0
  a_r3_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && none_set) |=> (out_code == 2'd0));
  // R4: full match in test mode gives 3
  a_r4_all_three: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_insert && !none_set && all_set) |=> (out_code == 2'd3));
  // R5: narrow test never reports 2
  a_r5_narrow_no_two: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && !in_insert) |=> (out_code != 2'd2));
  // R8: insert mode never reports 3
  a_r8_insert_no_three: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insert) |=> (out_code != 2'd3));
  // R10: the count points at a set mask bit with no set bit above it
  a_r10_lead_is_set: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_zero |-> eff_mask[lead_idx]);
  a_r10_lead_pick: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_zero |-> (lead_bit == eff_value[lead_idx]));
  // R9: narrow width leaves an upper-half-only mask at count 64
  a_r9_narrow_hides_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_wide && (in_mask[NARROW_W-1:0] == '0)) |-> mask_zero);

endmodule

// File: tb/tb_mbt_cond_unit.sv
`timescale 1ns/1ps
module tb_mbt_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_value = '0;
  logic [63:0] in_mask = '0;
  logic        in_wide = 1'b0;
  logic        in_insert = 1'b0;
  logic        out_valid;
  logic [1:0]  out_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] last_code = 2'd0;

  always #2 clk = ~clk;

  mbt_cond_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_mask(in_mask), .in_wide(in_wide), .in_insert(in_insert),
    .out_valid(out_valid), .out_code(out_code)
  );

  function automatic logic [1:0] ref_code(input logic [63:0] v, input logic [63:0] m,
                                          input logic w, input logic ins);
    logic [63:0] vv, mm, r;
    int top;
    logic lb;
    vv = w ? v : {32'd0, v[31:0]};
    mm = w ? m : {32'd0, m[31:0]};
    r = vv & mm;
    top = -1;
    for (int i = 63; i >= 0; i--) if (mm[i] && top < 0) top = i;
    lb = (top >= 0) ? vv[top] : 1'b0;
    if (r == 64'd0) return 2'd0;
    if (ins) return lb ? 2'd1 : 2'd2;
    if (r == mm) return 2'd3;
    if (!w) return 2'd1;
    return lb ? 2'd2 : 2'd1;
  endfunction

  function automatic string req_of(input logic [63:0] v, input logic [63:0] m,
                                   input logic w, input logic ins);
    logic [63:0] vv, mm;
    vv = w ? v : {32'd0, v[31:0]};
    mm = w ? m : {32'd0, m[31:0]};
    if (ins) return ((vv & mm) == 0) ? "R7" : "R8";
    if ((vv & mm) == 0) return "R3";
    if ((vv & mm) == mm) return "R4";
    return w ? "R6" : "R5";
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; result is registered at the next rise and read at the next fall.
  task automatic run(input logic [63:0] v, input logic [63:0] m, input logic w,
                     input logic ins, input string tag);
    logic [1:0] e;
    in_valid = 1'b1; in_value = v; in_mask = m; in_wide = w; in_insert = ins;
    e = ref_code(v, m, w, ins);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check(tag.len() > 0 ? tag : req_of(v, m, w, ins), 64'(out_code), 64'(e));
    last_code = e;
  endtask

  task automatic run_auto(input logic [63:0] v, input logic [63:0] m, input logic w,
                          input logic ins);
    run(v, m, w, ins, req_of(v, m, w, ins));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] m, v, r;
    int unsigned sel;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 valid", 64'(out_valid), 64'd0);
    check("R2 code", 64'(out_code), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after", 64'(out_valid), 64'd0);

    // Directed corner cases
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 1'b0, "R3 zero mask");
    run(64'h0F0F, 64'hF0F0, 1'b1, 1'b0, "R3");
    run(64'hF0F0_0000_0000_00F0, 64'hF000_0000_0000_00F0, 1'b1, 1'b0, "R4");
    run(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 1'b1, 1'b0, "R6 lead set");
    run(64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b1, 1'b0, "R6 lead clear");
    run(64'h0000_0000_0000_0080, 64'h0000_0000_0000_00C0, 1'b1, 1'b0, "R6 low lead");
    run(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0001, 1'b0, 1'b0, "R5");
    run(64'h0000_0000_0000_0000, 64'h0000_0000_0000_00FF, 1'b1, 1'b1, "R7");
    run(64'h0000_0000_0000_0080, 64'h0000_0000_0000_00FF, 1'b1, 1'b1, "R8 lead set");
    run(64'h0000_0000_0000_0001, 64'h0000_0000_0000_00FF, 1'b1, 1'b1, "R8 lead clear");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R8 full");
    run(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0, "R9 upper only");
    run(64'h8000_0000_0000_0002, 64'h8000_0000_0000_0003, 1'b0, 1'b1, "R9 narrow lead");
    run(64'h0000_0000_8000_0001, 64'h8000_0000_8000_0003, 1'b1, 1'b0, "R10 wide lead");
    run(64'h0000_0000_4000_0000, 64'h0000_0000_4000_0001, 1'b0, 1'b1, "R10 narrow lead");

    // R1: idle cycles with moving inputs hold the code
    for (int k = 0; k < 4; k++) begin
      in_value = {$urandom, $urandom};
      in_mask = {$urandom, $urandom};
      in_wide = k[0]; in_insert = k[1];
      @(negedge clk);
      check("R1 idle valid", 64'(out_valid), 64'd0);
      check("R1 hold", 64'(out_code), 64'(last_code));
    end

    // Random stimulus shaped to reach every outcome
    for (int n = 0; n < 3000; n++) begin
      sel = $urandom % 6;
      m = {$urandom, $urandom};
      if (sel == 0) m = 64'd1 << ($urandom % 64);
      if (sel == 1) m = m >> ($urandom % 64);
      r = {$urandom, $urandom};
      case ($urandom % 4)
        0: v = m | (r & ~m);
        1: v = (m & r) | (~m & {$urandom, $urandom});
        2: v = ~m;
        default: v = r;
      endcase
      run_auto(v, m, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule